// File: doc/BRIEF.md
# Adaptive On-Time Switching Sequencer

This block is the digital heart of a synchronous buck controller. It converts two comparator flags into the high-side and low-side gate enables of the power stage. One flag says the feedback voltage has dropped under its reference. The other says the low-side switch current is above the limit. Each on-period has a fixed length, given as a cycle count on an input word. An upstream estimator computes that count from the input and output voltages. The off-period has no timer of its own. It ends when feedback drops under the reference again, but never before a minimum off-time that keeps the bootstrap capacitor topped up. Every change of drive direction passes through a dead-time window in which both switches are off.

During the off-period the current-limit flag is ignored for a blanking window. After that window, an assertion of the flag ends switching at once. The block then pulses a restart request to a separate supervisor and keeps both switches off. It stays in that state until the supervisor drops the run enable. When the feedback flag stays low through a load step, back-to-back on-periods follow each other, separated only by the dead times and the minimum off-time. The switching frequency therefore rises for the length of the step.

All times are parameters counted in system clock cycles. The default parameters match a 100 MHz clock: 30 cycles of dead time, 15 cycles of blanking and 30 cycles of minimum off-time.

Top module: `aot_sequencer`

## Requirements
- R1: While reset is active or `run_en` is low, `hs_drv`, `ls_drv` and `restart_req` are 0. When `run_en` is taken low, both drives are 0 from the next clock on, and all internal timing restarts.
- R2: With `run_en` high and no switching in progress, the block waits for `fb_low`. When `fb_low` is seen, `hs_drv` rises after exactly DT_CYC cycles with both drives 0.
- R3: Each on-period holds `hs_drv`=1 and `ls_drv`=0 for exactly `ton_cycles` clock cycles. A value of 0 is treated as 1.
- R4: Between the fall of one drive and the rise of the other, there are exactly DT_CYC cycles in which both drives are 0.
- R5: `hs_drv` and `ls_drv` are never 1 in the same cycle.
- R6: Each off-period holds `ls_drv`=1 for at least MINOFF_CYC cycles. It ends after the first cycle in which that floor has been met and `fb_low` is 1. If `fb_low` is first seen in off-cycle F (counting from 0), the low-side pulse lasts max(F+1, MINOFF_CYC) cycles.
- R7: `oc_flag` has no effect during the on-period, during the dead times, or during the first BLANK_CYC cycles of an off-period.
- R8: If `oc_flag` is 1 in off-cycle BLANK_CYC or later, `ls_drv` falls at the next clock, both drives are 0, and `restart_req` is 1 for exactly one cycle. A flag held from the start of the off-period gives a low-side pulse of BLANK_CYC+1 cycles.
- R9: After a trip, both drives stay 0 whatever `fb_low` does. Normal operation resumes, as in R2, only after `run_en` has been low for at least one cycle.
- R10: A change on `ton_cycles` during an on-period does not alter that on-period. The new value sets the length of the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| run_en | input | 1 | 1 allows switching; 0 forces both drives off and restarts timing |
| fb_low | input | 1 | Feedback-below-reference comparator flag |
| oc_flag | input | 1 | Low-side over-current comparator flag |
| ton_cycles | input | TON_W | On-period length in clock cycles |
| hs_drv | output | 1 | High-side gate enable |
| ls_drv | output | 1 | Low-side gate enable |
| restart_req | output | 1 | One-cycle request to the supervisor for a soft-start restart |

## Verification
The internal state register, the shared cycle timer and the latched on-time word each leave a mark on the drive pulses. A wrong state shows up directly as a drive pulse of the wrong width, a missing or shortened dead gap, or an overlap, and it appears in the same switching cycle. A timer that is not cleared or compared correctly shows up as a pulse off by one or more cycles, visible at the very next edge of a drive. A trip outside the blanking window, or a missing trip, shows up in the off-period where it happens, as a low-side pulse of unexpected length and a restart pulse that is present or absent.

// File: rtl/aot_pkg.sv
package aot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DT_ON  = 3'd1,
    ST_ON     = 3'd2,
    ST_DT_OFF = 3'd3,
    ST_OFF    = 3'd4,
    ST_TRIP   = 3'd5,
    ST_HALT   = 3'd6
  } aot_state_e;

  // Width of a counter that must hold the largest timing limit and any on-time word.
  function automatic int cnt_bits(int ton_w, int dt, int blank, int minoff);
    int m;
    int w;
    m = dt;
    if (blank > m) m = blank;
    if (minoff > m) m = minoff;
    w = $clog2(m + 1);
    if (ton_w > w) w = ton_w;
    return w;
  endfunction

endpackage

// File: rtl/aot_timer.sv
module aot_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_nxt;
  logic         adv;

  // Counter saturates so that a long off-period never wraps back into a short count.
  always_comb begin
    adv     = !clr && (cnt != CNT_MAX);
    cnt_nxt = cnt;
    if (clr)      cnt_nxt = '0;
    else if (adv) cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

endmodule

// File: rtl/aot_ctrl.sv
module aot_ctrl
  import aot_pkg::*;
#(
  parameter int TON_W      = 10,
  parameter int DT_CYC     = 30,
  parameter int BLANK_CYC  = 15,
  parameter int MINOFF_CYC = 30,
  parameter int CNT_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             fb_low,
  input  logic             oc_flag,
  input  logic [TON_W-1:0] ton_cycles,
  input  logic [CNT_W-1:0] cnt,
  output logic             tmr_clr,
  output logic             hs_nxt,
  output logic             ls_nxt,
  output logic             trip_nxt
);
  localparam logic [CNT_W-1:0] DT_LAST     = CNT_W'(DT_CYC - 1);
  localparam logic [CNT_W-1:0] MINOFF_LAST = CNT_W'(MINOFF_CYC - 1);
  localparam logic [CNT_W-1:0] BLANK_L     = CNT_W'(BLANK_CYC);

  aot_state_e       state, state_nxt;
  logic [TON_W-1:0] ton_q;
  logic             ton_ld;
  logic [CNT_W-1:0] ton_last;

  // A zero on-time word still gives a one-cycle on-period.
  always_comb begin
    ton_last = '0;
    if (ton_q != '0) ton_last = CNT_W'(ton_q - 1'b1);
  end

  always_comb begin
    state_nxt = state;
    if (!run_en) begin
      state_nxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:   if (fb_low) state_nxt = ST_DT_ON;
        ST_DT_ON:  if (cnt == DT_LAST) state_nxt = ST_ON;
        ST_ON:     if (cnt == ton_last) state_nxt = ST_DT_OFF;
        ST_DT_OFF: if (cnt == DT_LAST) state_nxt = ST_OFF;
        ST_OFF: begin
          // Current limit takes priority over the feedback-driven exit.
          if (oc_flag && (cnt >= BLANK_L))          state_nxt = ST_TRIP;
          else if (fb_low && (cnt >= MINOFF_LAST))  state_nxt = ST_DT_ON;
        end
        ST_TRIP:   state_nxt = ST_HALT;
        ST_HALT:   state_nxt = ST_HALT;
        default:   state_nxt = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tmr_clr  = (state_nxt != state) || !run_en;
    ton_ld   = (state_nxt == ST_ON) && (state != ST_ON);
    hs_nxt   = (state_nxt == ST_ON);
    ls_nxt   = (state_nxt == ST_OFF);
    trip_nxt = (state_nxt == ST_TRIP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ton_q <= '0;
    else if (ton_ld) ton_q <= ton_cycles;
  end

  // R10: the latched on-time word does not move while an on-period runs.
  a_r10_ton_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ON && state_nxt == ST_ON) |=> $stable(ton_q));

  // R7: a trip only follows an off-period cycle at or beyond the blanking count.
  a_r7_trip_after_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRIP) |-> ($past(state) == ST_OFF && $past(cnt) >= BLANK_L));

endmodule

// File: rtl/aot_drive.sv
module aot_drive #(
  parameter int DT_CYC = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_nxt,
  input  logic ls_nxt,
  input  logic trip_nxt,
  output logic hs_drv,
  output logic ls_drv,
  output logic restart_req
);
  localparam int              GAP_W   = $clog2(DT_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(DT_CYC);

  logic [GAP_W-1:0] gap_q, gap_nxt;

  // Gate enables leave the block straight from flops, free of decode glitches.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_drv      <= 1'b0;
      ls_drv      <= 1'b0;
      restart_req <= 1'b0;
    end else begin
      hs_drv      <= hs_nxt;
      ls_drv      <= ls_nxt && !hs_nxt;
      restart_req <= trip_nxt;
    end
  end

  // Count of consecutive cycles with both switches off, saturating at the dead time.
  always_comb begin
    gap_nxt = gap_q;
    if (hs_drv || ls_drv)     gap_nxt = '0;
    else if (gap_q != GAP_MAX) gap_nxt = gap_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= GAP_MAX;
    else        gap_q <= gap_nxt;
  end

  // R5: no shoot-through.
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_drv && ls_drv));

  // R4: a drive may only rise after a full dead-time gap.
  a_r4_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_drv) || $rose(ls_drv)) |-> (gap_q >= GAP_MAX));

  // R8: the restart request is a single-cycle pulse.
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !restart_req);

endmodule

// File: rtl/aot_sequencer.sv
module aot_sequencer #(
  parameter int TON_W      = 10,
  parameter int DT_CYC     = 30,
  parameter int BLANK_CYC  = 15,
  parameter int MINOFF_CYC = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             fb_low,
  input  logic             oc_flag,
  input  logic [TON_W-1:0] ton_cycles,
  output logic             hs_drv,
  output logic             ls_drv,
  output logic             restart_req
);
  localparam int CNT_W = aot_pkg::cnt_bits(TON_W, DT_CYC, BLANK_CYC, MINOFF_CYC);
  localparam int LSW_W = $clog2(MINOFF_CYC + 1);
  localparam logic [LSW_W-1:0] LSW_MAX = LSW_W'(MINOFF_CYC);

  logic             tmr_clr;
  logic [CNT_W-1:0] cnt;
  logic             hs_nxt, ls_nxt, trip_nxt;

  aot_timer #(.W(CNT_W)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .cnt   (cnt)
  );

  aot_ctrl #(
    .TON_W      (TON_W),
    .DT_CYC     (DT_CYC),
    .BLANK_CYC  (BLANK_CYC),
    .MINOFF_CYC (MINOFF_CYC),
    .CNT_W      (CNT_W)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .fb_low     (fb_low),
    .oc_flag    (oc_flag),
    .ton_cycles (ton_cycles),
    .cnt        (cnt),
    .tmr_clr    (tmr_clr),
    .hs_nxt     (hs_nxt),
    .ls_nxt     (ls_nxt),
    .trip_nxt   (trip_nxt)
  );

  aot_drive #(.DT_CYC(DT_CYC)) i_drive (
    .clk         (clk),
    .rst_n       (rst_n),
    .hs_nxt      (hs_nxt),
    .ls_nxt      (ls_nxt),
    .trip_nxt    (trip_nxt),
    .hs_drv      (hs_drv),
    .ls_drv      (ls_drv),
    .restart_req (restart_req)
  );

  // Width of the current low-side pulse, saturating at the minimum off-time.
  logic [LSW_W-1:0] lsw_q, lsw_nxt;

  always_comb begin
    lsw_nxt = lsw_q;
    if (!ls_drv)               lsw_nxt = '0;
    else if (lsw_q != LSW_MAX) lsw_nxt = lsw_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lsw_q <= '0;
    else        lsw_q <= lsw_nxt;
  end

  // R6: a low-side pulse that ends normally meets the minimum off-time.
  a_r6_min_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ls_drv) && $past(run_en) && !restart_req) |-> (lsw_q >= LSW_MAX));

  // R1: disabling forces the outputs quiet on the next clock.
  a_r1_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!hs_drv && !ls_drv && !restart_req));

  // R8: a restart request follows an over-current flag seen during the low-side pulse.
  a_r8_trip_cause: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |-> ($past(ls_drv) && $past(oc_flag)));

endmodule

// File: tb/test_aot_sequencer.sv
module test_aot_sequencer;
  localparam int TW = 10;
  localparam int DT = 30;
  localparam int BL = 15;
  localparam int MO = 30;
  localparam int NV = 6;
  // Each entry: on-time word, off-cycle in which fb_low is raised.
  localparam int VEC [NV][2] = '{'{8, 0}, '{1, 5}, '{0, 40}, '{100, 29}, '{37, 28}, '{3, 30}};

  logic clk = 1'b0;
  logic rst_n, run_en, fb_low, oc_flag;
  logic [TW-1:0] ton;
  logic hs, ls, rq;

  int checks = 0;
  int fails = 0;
  int overlap = 0;
  int rq_seen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  aot_sequencer #(.TON_W(TW), .DT_CYC(DT), .BLANK_CYC(BL), .MINOFF_CYC(MO)) i_aot_sequencer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .fb_low(fb_low), .oc_flag(oc_flag),
    .ton_cycles(ton), .hs_drv(hs), .ls_drv(ls), .restart_req(rq)
  );

  always @(negedge clk) begin
    if (hs === 1'b1 && ls === 1'b1) overlap++;
    if (rq === 1'b1) rq_seen++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_hs(output int w);
    w = 0;
    while (hs !== 1'b1 && w < 5000) begin @(negedge clk); w++; end
  endtask

  task automatic count_hs(input int chg_at, input int chg_val, output int n);
    n = 0;
    while (hs === 1'b1 && n < 5000) begin
      if (n == chg_at) ton = TW'(chg_val);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic count_gap(output int n);
    n = 0;
    while (hs !== 1'b1 && ls !== 1'b1 && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic count_ls(input int fb_at, input int oc_clr_at, output int n);
    n = 0;
    while (ls === 1'b1 && n < 5000) begin
      if (n == fb_at) fb_low = 1'b1;
      if (n == oc_clr_at) oc_flag = 1'b0;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic quiet_for(input int n, output int act);
    act = 0;
    for (int k = 0; k < n; k++) begin
      if (hs === 1'b1 || ls === 1'b1) act++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int w, h, g, l, a, base, t, f, eh, el;
    rst_n = 1'b0; run_en = 1'b0; fb_low = 1'b0; oc_flag = 1'b0; ton = TW'(8);
    step(3);
    chk(hs === 1'b0 && ls === 1'b0 && rq === 1'b0, "R1 reset outputs", {hs, ls, rq}, 0);
    rst_n = 1'b1;
    step(2);

    // R2: waits for feedback, then dead time, then on.
    run_en = 1'b1;
    quiet_for(40, a);
    chk(a == 0, "R2 wait for fb_low", a, 0);
    fb_low = 1'b1;
    step(DT);
    chk(hs === 1'b0, "R2 dead time before first on", hs, 0);
    step(1);
    chk(hs === 1'b1, "R2 first on", hs, 1);

    // Vector table: R3 on width, R4 gaps, R6 off width.
    for (int i = 0; i < NV; i++) begin
      t = VEC[i][0];
      f = VEC[i][1];
      eh = (t == 0) ? 1 : t;
      el = (f + 1 > MO) ? f + 1 : MO;
      run_en = 1'b0; fb_low = 1'b1; ton = TW'(t);
      step(2);
      run_en = 1'b1;
      wait_hs(w);
      fb_low = 1'b0;
      count_hs(-1, 0, h);
      chk(h == eh, "R3 on width", h, eh);
      count_gap(g);
      chk(g == DT, "R4 gap hs to ls", g, DT);
      count_ls(f, -1, l);
      chk(l == el, "R6 off width", l, el);
      count_gap(g);
      chk(g == DT, "R4 gap ls to hs", g, DT);
      chk(hs === 1'b1, "R6 next on follows", hs, 1);
    end

    // R1: disable during an on-period.
    run_en = 1'b0;
    step(1);
    chk(hs === 1'b0 && ls === 1'b0, "R1 disable mid on", {hs, ls}, 0);
    quiet_for(20, a);
    chk(a == 0, "R1 stays off while disabled", a, 0);

    // R7: flag during on, dead time and blanking is ignored.
    ton = TW'(10); fb_low = 1'b1; run_en = 1'b1;
    wait_hs(w);
    oc_flag = 1'b1;
    base = rq_seen;
    count_hs(-1, 0, h);
    count_gap(g);
    count_ls(-1, BL, l);
    chk(l == MO, "R7 off width with blanked flag", l, MO);
    chk(rq_seen == base, "R7 no restart", rq_seen - base, 0);

    // R8: flag after blanking trips.
    wait_hs(w);
    count_hs(-1, 0, h);
    count_gap(g);
    oc_flag = 1'b1;
    count_ls(-1, -1, l);
    chk(l == BL + 1, "R8 low-side cut at blank end", l, BL + 1);
    chk(rq === 1'b1 && hs === 1'b0, "R8 restart pulse", {rq, hs}, 2);
    step(1);
    chk(rq === 1'b0, "R8 pulse one cycle", rq, 0);
    oc_flag = 1'b0;

    // R9: held off after trip until run_en cycles.
    quiet_for(50, a);
    chk(a == 0, "R9 held off after trip", a, 0);
    run_en = 1'b0;
    step(1);
    run_en = 1'b1;
    step(DT);
    chk(hs === 1'b0, "R9 dead time on restart", hs, 0);
    step(1);
    chk(hs === 1'b1, "R9 restart after run cycle", hs, 1);

    // R10: on-time word change mid on-period.
    run_en = 1'b0;
    step(2);
    ton = TW'(20); fb_low = 1'b1; run_en = 1'b1;
    wait_hs(w);
    count_hs(2, 5, h);
    chk(h == 20, "R10 current on unchanged", h, 20);
    count_gap(g);
    count_ls(-1, -1, l);
    count_gap(g);
    count_hs(-1, 0, h);
    chk(h == 5, "R10 next on uses new word", h, 5);

    chk(overlap == 0, "R5 no overlap", overlap, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule